// File: doc/BRIEF.md
# Swizzled Banked Transpose Buffer

This block holds one tile of 16 rows by 32 columns of 32-bit words in a scratchpad of 32 single-port banks, and turns it around. A group of 32 lanes fills the tile one row per store beat. It then drains the tile one column pair per read beat. On a read beat, the low lane bits pick the row and the top lane bit picks which column of the pair is fetched. The read side is therefore the transposed view of what was written.

Where each element sits among the banks is a build-time choice. The choices are a plain layout, an XOR of the column by the row, or an XOR of the column by twice the row. In the last mode, the row index never touches the column parity bit. Every store beat and every read beat then meets each bank exactly once, so each beat takes one cycle. In the other two modes the read beats collide on banks. The block then holds its read handshake low and serves the lanes over extra cycles, with the lowest lane winning each bank, until every lane has its word.

Both ports use valid/ready handshakes. Read results leave through a registered output slot with its own valid/ready pair. A tile-full flag shows when all rows are in, and it drops again after the last read beat.

Top module: `swz_transpose_buf`

## Requirements
- R1: After reset, st_ready is 1, tile_full is 0 and out_valid is 0.
- R2: A store beat for row m, the m-th beat accepted since the tile was empty, writes lane t's word (bits 32t+31..32t of st_data) as element (m, t). In every mode st_ready stays 1 for all 16 beats, so each store beat completes in one cycle.
- R3: tile_full rises on the edge that accepts the 16th store beat. While it is 1, st_ready is 0.
- R4: While tile_full is 0, rd_ready stays 0 even if rd_valid is 1.
- R5: The result of read beat r (r = 0..15, counted in order) carries element (t mod 16, 2r + t/16) on output slot t, for every lane t.
- R6: Mode 2 (XOR by 2m) places element (m, n) in bank n XOR (2m mod 32), segment m. A read beat that is presented with tile_full 1 and a free output slot is accepted in that same cycle.
- R7: Mode 1 (XOR by m) places element (m, n) in bank n XOR m. Each read beat needs 2 cycles from the first cycle rd_valid is seen to the cycle rd_ready is 1.
- R8: Mode 0 (plain) places element (m, n) in bank n. Each read beat needs 16 cycles.
- R9: out_valid is 1 in the cycle after a read beat is accepted. While out_valid is 1 and out_ready is 0, out_valid and out_data hold and no new read beat is accepted.
- R10: The edge that accepts the 16th read beat clears tile_full. The next store beat then writes row 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store beat offered |
| st_ready | output | 1 | Store beat accepted this cycle when valid |
| st_data | input | 1024 | One row, lane t in bits 32t+31..32t |
| rd_valid | input | 1 | Read beat requested |
| rd_ready | output | 1 | Read beat completes this cycle |
| out_valid | output | 1 | Output slot holds a read result |
| out_ready | input | 1 | Consumer takes the output slot |
| out_data | output | 1024 | Read result, lane t in bits 32t+31..32t |
| tile_full | output | 1 | All 16 rows stored, tile not yet drained |

## Verification
A store is written on the edge that accepts it, and tile_full shows one edge after the 16th acceptance. rd_ready is combinational in the cycle that serves the last lane. That cycle is the first, the second or the sixteenth cycle of a beat for modes 2, 1 and 0. The result shows on out_valid and out_data one edge after acceptance. The bench drives inputs and samples 1 ns after each falling clock edge. It counts cycles between those samples to measure the beat length, and it reads the output at the first falling edge after the accepting edge.

// File: rtl/swz_pkg.sv
package swz_pkg;

   typedef enum logic [1:0] {
      SWZ_NONE = 2'd0,
      SWZ_ROW  = 2'd1,
      SWZ_ROW2 = 2'd2
   } swz_mode_e;

   // Column offset that a row index contributes to the bank number.
   function automatic logic [7:0] swz_fold(input swz_mode_e mode, input logic [7:0] row);
      logic [7:0] f;
      case (mode)
         SWZ_ROW:  f = row;
         SWZ_ROW2: f = {row[6:0], 1'b0};
         default:  f = 8'd0;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/swz_bank_array.sv
module swz_bank_array #(
   parameter int BANKS = 32,
   parameter int DEPTH = 16,
   parameter int DW    = 32
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_seg,
   input  logic [BANKS*DW-1:0]      wr_data,
   input  logic [BANKS*$clog2(DEPTH)-1:0] rd_seg,
   output logic [BANKS*DW-1:0]      rd_data
);
   localparam int SEG_W = $clog2(DEPTH);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_seg] <= wr_data[b*DW +: DW];
      end

      assign rd_data[b*DW +: DW] = mem[rd_seg[b*SEG_W +: SEG_W]];
   end

endmodule

// File: rtl/swz_read_xbar.sv
module swz_read_xbar
   import swz_pkg::*;
#(
   parameter int        LANES = 32,
   parameter int        ROWS  = 16,
   parameter int        DW    = 32,
   parameter swz_mode_e MODE  = SWZ_ROW2
) (
   input  logic [$clog2(ROWS)-1:0]       beat,
   input  logic [LANES-1:0]              pending,
   input  logic [LANES*DW-1:0]           bank_rdata,
   output logic [LANES*$clog2(ROWS)-1:0] bank_rseg,
   output logic [LANES-1:0]              served,
   output logic [LANES*DW-1:0]           lane_data
);
   localparam int LANE_W = $clog2(LANES);
   localparam int ROW_W  = $clog2(ROWS);

   logic [LANE_W-1:0] lane_bank [LANES];
   logic [LANES-1:0]  gnt_v;
   logic [LANE_W-1:0] gnt_l [LANES];

   // Lane t reads row t[ROW_W-1:0] of column {beat, top lane bit}.
   for (genvar t = 0; t < LANES; t++) begin : g_lane
      localparam logic [LANE_W-1:0] LID = LANE_W'(t);
      logic [ROW_W-1:0]  row;
      logic [LANE_W-1:0] col;
      assign row = LID[ROW_W-1:0];
      assign col = {beat, LID[LANE_W-1]};
      assign lane_bank[t] = col ^ LANE_W'(swz_fold(MODE, 8'(row)));
      assign served[t] = pending[t] && gnt_v[lane_bank[t]]
                         && (gnt_l[lane_bank[t]] == LANE_W'(t));
      assign lane_data[t*DW +: DW] = bank_rdata[lane_bank[t]*DW +: DW];
   end

   // Each bank serves the lowest pending lane that targets it.
   always_comb begin
      for (int b = 0; b < LANES; b++) begin
         gnt_v[b] = 1'b0;
         gnt_l[b] = '0;
         for (int t = LANES - 1; t >= 0; t--) begin
            if (pending[t] && (lane_bank[t] == LANE_W'(b))) begin
               gnt_v[b] = 1'b1;
               gnt_l[b] = LANE_W'(t);
            end
         end
      end
   end

   for (genvar b = 0; b < LANES; b++) begin : g_seg
      assign bank_rseg[b*ROW_W +: ROW_W] = gnt_l[b][ROW_W-1:0];
   end

endmodule

// File: rtl/swz_transpose_buf.sv
module swz_transpose_buf
   import swz_pkg::*;
#(
   parameter int        LANES = 32,
   parameter int        ROWS  = 16,
   parameter int        DW    = 32,
   parameter swz_mode_e MODE  = SWZ_ROW2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                st_valid,
   output logic                st_ready,
   input  logic [LANES*DW-1:0] st_data,
   input  logic                rd_valid,
   output logic                rd_ready,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [LANES*DW-1:0] out_data,
   output logic                tile_full
);
   localparam int LANE_W = $clog2(LANES);
   localparam int ROW_W  = $clog2(ROWS);
   localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

   if (LANES != 2 * ROWS) begin : g_bad_shape
      $error("LANES must be twice ROWS");
   end
   if ((1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (ROW_W > 7) begin : g_bad_rows
      $error("ROWS too large for the fold function");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be positive");
   end

   logic [ROW_W-1:0]        wr_row, rd_beat;
   logic                    full_q, ov_q;
   logic [LANES-1:0]        pending, served;
   logic [LANES*DW-1:0]     bank_wdata, bank_rdata, lane_data;
   logic [LANES*ROW_W-1:0]  bank_rseg;
   logic [LANE_W-1:0]       wr_fold;
   logic                    st_fire, slot_free, rd_active, beat_done;

   // Store path: a row permutes across the banks, so bank b takes one lane.
   assign wr_fold = LANE_W'(swz_fold(MODE, 8'(wr_row)));

   for (genvar b = 0; b < LANES; b++) begin : g_wsel
      logic [LANE_W-1:0] src;
      assign src = LANE_W'(b) ^ wr_fold;
      assign bank_wdata[b*DW +: DW] = st_data[src*DW +: DW];
   end

   assign st_ready = !full_q;
   assign st_fire  = st_valid && st_ready;

   swz_bank_array #(
      .BANKS (LANES),
      .DEPTH (ROWS),
      .DW    (DW)
   ) u_banks (
      .clk     (clk),
      .wr_en   (st_fire),
      .wr_seg  (wr_row),
      .wr_data (bank_wdata),
      .rd_seg  (bank_rseg),
      .rd_data (bank_rdata)
   );

   swz_read_xbar #(
      .LANES (LANES),
      .ROWS  (ROWS),
      .DW    (DW),
      .MODE  (MODE)
   ) u_xbar (
      .beat       (rd_beat),
      .pending    (pending),
      .bank_rdata (bank_rdata),
      .bank_rseg  (bank_rseg),
      .served     (served),
      .lane_data  (lane_data)
   );

   assign slot_free = !ov_q || out_ready;
   assign rd_active = rd_valid && full_q && slot_free;
   assign beat_done = ((pending & ~served) == '0);
   assign rd_ready  = rd_active && beat_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_row  <= '0;
         rd_beat <= '0;
         full_q  <= 1'b0;
         pending <= '1;
         ov_q    <= 1'b0;
      end else begin
         if (st_fire) begin
            wr_row <= wr_row + 1'b1;
            if (wr_row == LAST) full_q <= 1'b1;
         end
         if (rd_active) begin
            pending <= beat_done ? '1 : (pending & ~served);
         end
         if (rd_ready) begin
            rd_beat <= rd_beat + 1'b1;
            if (rd_beat == LAST) full_q <= 1'b0;
         end
         if (rd_ready)       ov_q <= 1'b1;
         else if (out_ready) ov_q <= 1'b0;
      end
   end

   // Output slot: each lane captures its word in the cycle it is served.
   for (genvar t = 0; t < LANES; t++) begin : g_obuf
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rd_active && served[t]) word_q <= lane_data[t*DW +: DW];
      end
      assign out_data[t*DW +: DW] = word_q;
   end

   assign out_valid = ov_q;
   assign tile_full = full_q;

endmodule

// File: rtl/swz_transpose_chk.sv
module swz_transpose_chk
   import swz_pkg::*;
#(
   parameter int        LANES = 32,
   parameter int        DW    = 32,
   parameter swz_mode_e MODE  = SWZ_ROW2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                st_valid,
   input logic                st_ready,
   input logic                rd_valid,
   input logic                rd_ready,
   input logic                out_valid,
   input logic                out_ready,
   input logic [LANES*DW-1:0] out_data,
   input logic                tile_full
);

   // R3: the tile only fills on an accepted store beat
   a_r3_full_from_store: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tile_full) |-> $past(st_valid && st_ready));

   // R4: no read beat completes on an unfilled tile
   a_r4_read_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> tile_full);

   // R9: an accepted beat shows up in the output slot
   a_r9_out_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |=> out_valid);

   // R9: a stalled output slot holds its contents
   a_r9_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9: no acceptance while the slot is blocked
   a_r9_no_accept_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !rd_ready);

   // R10: the tile only empties on an accepted read beat
   a_r10_empty_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tile_full) |-> $past(rd_ready));

   if (MODE == SWZ_ROW2) begin : g_opt
      // R6: conflict-free placement serves every read beat in one cycle
      a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_valid && tile_full && (!out_valid || out_ready)) |-> rd_ready);
   end

endmodule

bind swz_transpose_buf swz_transpose_chk #(
   .LANES (LANES),
   .DW    (DW),
   .MODE  (MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .st_ready  (st_ready),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .tile_full (tile_full)
);

// File: tb/sim_swz_transpose_buf.sv
module sim_swz_transpose_buf;
   import swz_pkg::*;

   localparam int LANES = 32;
   localparam int ROWS  = 16;
   localparam int DW    = 32;
   localparam int NV    = 6;

   // {instance[9:8], backpressure[7], expected cycles per read beat[6:0]}
   // instance 0: mode 2 (R6), 1: mode 1 (R7), 2: mode 0 (R8)
   localparam logic [9:0] VEC [NV] = '{
      {2'd0, 1'b0, 7'd1},
      {2'd1, 1'b0, 7'd2},
      {2'd2, 1'b0, 7'd16},
      {2'd0, 1'b1, 7'd1},
      {2'd1, 1'b1, 7'd2},
      {2'd2, 1'b1, 7'd16}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                st_valid  [3];
   logic                rd_valid  [3];
   logic                out_ready [3];
   logic [LANES*DW-1:0] st_data   [3];
   logic                st_ready  [3];
   logic                rd_ready  [3];
   logic                out_valid [3];
   logic                tile_full [3];
   logic [LANES*DW-1:0] out_data  [3];

   int n_chk = 0;
   int n_bad = 0;

   swz_transpose_buf #(.LANES(LANES), .ROWS(ROWS), .DW(DW), .MODE(SWZ_ROW2)) u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid[0]), .st_ready(st_ready[0]),
      .st_data(st_data[0]), .rd_valid(rd_valid[0]), .rd_ready(rd_ready[0]),
      .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_data(out_data[0]),
      .tile_full(tile_full[0]));

   swz_transpose_buf #(.LANES(LANES), .ROWS(ROWS), .DW(DW), .MODE(SWZ_ROW)) u1 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid[1]), .st_ready(st_ready[1]),
      .st_data(st_data[1]), .rd_valid(rd_valid[1]), .rd_ready(rd_ready[1]),
      .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_data(out_data[1]),
      .tile_full(tile_full[1]));

   swz_transpose_buf #(.LANES(LANES), .ROWS(ROWS), .DW(DW), .MODE(SWZ_NONE)) u2 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid[2]), .st_ready(st_ready[2]),
      .st_data(st_data[2]), .rd_valid(rd_valid[2]), .rd_ready(rd_ready[2]),
      .out_valid(out_valid[2]), .out_ready(out_ready[2]), .out_data(out_data[2]),
      .tile_full(tile_full[2]));

   function automatic logic [31:0] elem(input int run, input int m, input int n);
      return {8'(8'hA0 ^ 8'(run)), 8'(m), 8'(n), 8'h5C};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_tile(input int i, input int exp_cyc, input bit bp, input int run);
      string cyc_req;
      logic [LANES*DW-1:0] held;
      bit fire;
      int cyc;
      cyc_req = (i == 0) ? "R6" : ((i == 1) ? "R7" : "R8");
      #1;
      chk(tile_full[i] == 1'b0, "R10", 32'(tile_full[i]), 32'd0);
      // Fill the tile, requesting reads the whole time (R2, R4)
      for (int m = 0; m < ROWS; m++) begin
         for (int t = 0; t < LANES; t++) st_data[i][t*DW +: DW] = elem(run, m, t);
         st_valid[i] = 1'b1;
         rd_valid[i] = 1'b1;
         #1;
         chk(st_ready[i] == 1'b1, "R2", 32'(st_ready[i]), 32'd1);
         chk(rd_ready[i] == 1'b0, "R4", 32'(rd_ready[i]), 32'd0);
         @(posedge clk);
         @(negedge clk);
      end
      st_valid[i] = 1'b0;
      rd_valid[i] = 1'b0;
      #1;
      chk(tile_full[i] == 1'b1, "R3", 32'(tile_full[i]), 32'd1);
      chk(st_ready[i] == 1'b0, "R3", 32'(st_ready[i]), 32'd0);
      // Drain the tile one column pair per beat
      for (int r = 0; r < ROWS; r++) begin
         rd_valid[i] = 1'b1;
         cyc = 0;
         do begin
            #1;
            fire = rd_ready[i];
            cyc++;
            @(posedge clk);
            @(negedge clk);
         end while (!fire);
         rd_valid[i] = 1'b0;
         #1;
         chk(cyc == exp_cyc, cyc_req, 32'(cyc), 32'(exp_cyc));
         chk(out_valid[i] == 1'b1, "R9", 32'(out_valid[i]), 32'd1);
         for (int t = 0; t < LANES; t++) begin
            chk(out_data[i][t*DW +: DW] == elem(run, t % 16, 2*r + t/16), "R5",
                out_data[i][t*DW +: DW], elem(run, t % 16, 2*r + t/16));
         end
         if (bp && (r == 5 || r == ROWS - 1)) begin
            out_ready[i] = 1'b0;
            rd_valid[i]  = (r != ROWS - 1);
            held = out_data[i];
            for (int k = 0; k < 3; k++) begin
               #1;
               chk(rd_ready[i] == 1'b0, "R9", 32'(rd_ready[i]), 32'd0);
               @(posedge clk);
               @(negedge clk);
               #1;
               chk(out_valid[i] == 1'b1, "R9", 32'(out_valid[i]), 32'd1);
               chk(out_data[i] == held, "R9", out_data[i][31:0], held[31:0]);
            end
            out_ready[i] = 1'b1;
            rd_valid[i]  = 1'b0;
            @(posedge clk);
            @(negedge clk);
            #1;
            chk(out_valid[i] == 1'b0, "R9", 32'(out_valid[i]), 32'd0);
         end
      end
      chk(tile_full[i] == 1'b0, "R10", 32'(tile_full[i]), 32'd0);
      chk(st_ready[i] == 1'b1, "R10", 32'(st_ready[i]), 32'd1);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 3; i++) begin
         st_valid[i]  = 1'b0;
         rd_valid[i]  = 1'b0;
         out_ready[i] = 1'b1;
         st_data[i]   = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state of every instance
      for (int i = 0; i < 3; i++) begin
         chk(st_ready[i] == 1'b1, "R1", 32'(st_ready[i]), 32'd1);
         chk(tile_full[i] == 1'b0, "R1", 32'(tile_full[i]), 32'd0);
         chk(out_valid[i] == 1'b0, "R1", 32'(out_valid[i]), 32'd0);
      end
      @(negedge clk);
      // Table walk; repeated tiles per instance also cover R10 wrap to row 0
      for (int k = 0; k < NV; k++) begin
         run_tile(int'(VEC[k][9:8]), int'(VEC[k][6:0]), VEC[k][7], k);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule